// File: doc/BRIEF.md
# Revision Protection Guard

This block holds the access rights of a configuration store that keeps several design revisions. Each revision carries a read-protect flag and a write-protect flag. A command decoder upstream hands over one request per cycle: a command code and a revision index. The guard answers each request one cycle later with a grant or a deny and echoes the revision index. When it grants a request, it also updates its flags. The flash array uses the grant to decide whether to start the read, program or erase.

Write protection is sticky. The only way to lift it is an UNLOCK for a revision followed at once by an ERASE of that same revision. Read protection stops only readback and verify. Program and erase still proceed, and an erase of the protected revision removes the flag. A build-time option replaces the per-revision read flags with one flag for the whole array. In that variant only a whole-array erase removes read protection.

Top module: `rev_guard`

## Requirements
- R1: After reset every read-protect and write-protect flag is clear, so READ, PROGRAM and ERASE of any revision are granted, and `rsp_valid` is low until the first request.
- R2: A granted SET_RP for revision n makes later READs of n deny. READs of other revisions stay granted, and PROGRAM or ERASE of n are still granted.
- R3: A granted SET_WP for revision n makes later PROGRAM and ERASE requests for n deny.
- R4: An ERASE of a write-protected revision n is granted only when the request just before it was an UNLOCK of n. That erase clears both flags of n.
- R5: A pending UNLOCK is dropped by any request other than ERASE. An UNLOCK of revision m does not enable the erase of a different revision n.
- R6: With per-revision read flags, the read flag of n is cleared only by a granted ERASE of n or a granted ERASE_ALL. An erase of another revision leaves it set.
- R7: With the device-wide option, SET_RP of any revision blocks READ of every revision. Per-revision ERASE does not lift this, and only a granted ERASE_ALL clears it.
- R8: ERASE_ALL is denied while any revision is write-protected. When granted, it clears every read-protect flag.
- R9: Each request cycle produces exactly one `rsp_valid` pulse on the next cycle, carrying the grant and the request's revision index. A denied request changes no flag.
- R10: Command codes on `req_cmd`: 0 READ, 1 PROGRAM, 2 ERASE, 3 SET_RP, 4 SET_WP, 5 UNLOCK, 6 ERASE_ALL. Code 7 is always denied and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_cmd | input | 3 | Command code (R10) |
| req_rev | input | REV_W | Revision index of the request |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_grant | output | 1 | 1 = granted, 0 = denied |
| rsp_rev | output | REV_W | Revision index echoed from the request |

## Verification
The properties assume that `req_cmd` and `req_rev` are stable, known values whenever `req_valid` is high. They also assume `req_rev` is below NUM_REV. The bench drives requests only on falling edges, keeps every index within the four revisions, and holds the valid line low around reset. The UNLOCK/ERASE pairing is checked against the tracker state the block brings out. The stimulus places other commands and mismatched indexes between the two steps so that the cancel path is covered.

// File: rtl/rev_guard_pkg.sv
package rev_guard_pkg;
   typedef enum logic [2:0] {
      CMD_READ      = 3'd0,
      CMD_PROG      = 3'd1,
      CMD_ERASE     = 3'd2,
      CMD_SET_RP    = 3'd3,
      CMD_SET_WP    = 3'd4,
      CMD_UNLOCK    = 3'd5,
      CMD_ERASE_ALL = 3'd6,
      CMD_RSVD      = 3'd7
   } cmd_e;
endpackage

// File: rtl/rev_guard_rp.sv
// Read-protect storage: one flag per revision, or a single device-wide flag.
module rev_guard_rp #(
   parameter int NUM_REV     = 4,
   parameter bit DEVICE_WIDE = 1'b0,
   localparam int REV_W      = $clog2(NUM_REV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [REV_W-1:0]   set_rev,
   input  logic               clr_rev_en,
   input  logic [REV_W-1:0]   clr_rev,
   input  logic               clr_all,
   output logic [NUM_REV-1:0] rp_vec
);
   generate
      if (DEVICE_WIDE) begin : g_dev
         logic dev_q;
         logic unused_dw;
         assign unused_dw = ^{set_rev, clr_rev_en, clr_rev};
         always_ff @(posedge clk) begin
            if (!rst_n)       dev_q <= 1'b0;
            else if (clr_all) dev_q <= 1'b0;
            else if (set_en)  dev_q <= 1'b1;
         end
         assign rp_vec = {NUM_REV{dev_q}};
      end else begin : g_rev
         for (genvar i = 0; i < NUM_REV; i++) begin : g_bit
            logic q;
            always_ff @(posedge clk) begin
               if (!rst_n)                                   q <= 1'b0;
               else if (clr_all)                             q <= 1'b0;
               else if (clr_rev_en && clr_rev == REV_W'(i))  q <= 1'b0;
               else if (set_en && set_rev == REV_W'(i))      q <= 1'b1;
            end
            assign rp_vec[i] = q;
         end
      end
   endgenerate
endmodule

// File: rtl/rev_guard_wp.sv
// Write-protect flags plus the one-deep UNLOCK tracker.
module rev_guard_wp #(
   parameter int NUM_REV = 4,
   localparam int REV_W  = $clog2(NUM_REV)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_fire,
   input  logic [REV_W-1:0]   rev,
   input  logic               set_en,
   input  logic               clr_en,
   input  logic               unlock_en,
   output logic [NUM_REV-1:0] wp_vec,
   output logic               pend_v,
   output logic [REV_W-1:0]   pend_rev
);
   for (genvar i = 0; i < NUM_REV; i++) begin : g_wp
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)                              q <= 1'b0;
         else if (clr_en && rev == REV_W'(i))     q <= 1'b0;
         else if (set_en && rev == REV_W'(i))     q <= 1'b1;
      end
      assign wp_vec[i] = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v   <= 1'b0;
         pend_rev <= '0;
      end else if (req_fire) begin
         pend_v   <= unlock_en;
         pend_rev <= unlock_en ? rev : pend_rev;
      end
   end
endmodule

// File: rtl/rev_guard.sv
module rev_guard
   import rev_guard_pkg::*;
#(
   parameter int NUM_REV     = 4,
   parameter bit DEVICE_WIDE = 1'b0,
   localparam int REV_W      = $clog2(NUM_REV)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_cmd,
   input  logic [REV_W-1:0] req_rev,
   output logic             rsp_valid,
   output logic             rsp_grant,
   output logic [REV_W-1:0] rsp_rev
);
   generate
      if (NUM_REV < 2 || (1 << REV_W) != NUM_REV) begin : g_bad_num
         $error("rev_guard: NUM_REV must be a power of two, at least 2");
      end
   endgenerate

   cmd_e               cmd;
   logic [NUM_REV-1:0] rp_vec;
   logic [NUM_REV-1:0] wp_vec;
   logic               pend_v;
   logic [REV_W-1:0]   pend_rev;
   logic               grant;
   logic               rp_hit, wp_hit, unlock_match, any_wp;

   assign cmd          = cmd_e'(req_cmd);
   assign rp_hit       = rp_vec[req_rev];
   assign wp_hit       = wp_vec[req_rev];
   assign unlock_match = pend_v && (pend_rev == req_rev);
   assign any_wp       = |wp_vec;

   always_comb begin
      unique case (cmd)
         CMD_READ:      grant = !rp_hit;
         CMD_PROG:      grant = !wp_hit;
         CMD_ERASE:     grant = !wp_hit || unlock_match;
         CMD_SET_RP:    grant = 1'b1;
         CMD_SET_WP:    grant = 1'b1;
         CMD_UNLOCK:    grant = 1'b1;
         CMD_ERASE_ALL: grant = !any_wp;
         default:       grant = 1'b0;
      endcase
   end

   logic do_erase, do_erase_all;
   assign do_erase     = req_valid && cmd == CMD_ERASE && grant;
   assign do_erase_all = req_valid && cmd == CMD_ERASE_ALL && grant;

   rev_guard_rp #(.NUM_REV(NUM_REV), .DEVICE_WIDE(DEVICE_WIDE)) u_rp (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_en     (req_valid && cmd == CMD_SET_RP),
      .set_rev    (req_rev),
      .clr_rev_en (do_erase),
      .clr_rev    (req_rev),
      .clr_all    (do_erase_all),
      .rp_vec     (rp_vec)
   );

   rev_guard_wp #(.NUM_REV(NUM_REV)) u_wp (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_fire  (req_valid),
      .rev       (req_rev),
      .set_en    (req_valid && cmd == CMD_SET_WP),
      .clr_en    (do_erase),
      .unlock_en (cmd == CMD_UNLOCK),
      .wp_vec    (wp_vec),
      .pend_v    (pend_v),
      .pend_rev  (pend_rev)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_grant <= 1'b0;
         rsp_rev   <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= req_valid && grant;
         rsp_rev   <= req_valid ? req_rev : rsp_rev;
      end
   end
endmodule

// File: rtl/rev_guard_chk.sv
module rev_guard_chk
   import rev_guard_pkg::*;
#(
   parameter int NUM_REV     = 4,
   parameter bit DEVICE_WIDE = 1'b0,
   localparam int REV_W      = $clog2(NUM_REV)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [2:0]         req_cmd,
   input logic [REV_W-1:0]   req_rev,
   input logic               rsp_valid,
   input logic               rsp_grant,
   input logic [REV_W-1:0]   rsp_rev,
   input logic [NUM_REV-1:0] rp_vec,
   input logic [NUM_REV-1:0] wp_vec,
   input logic               pend_v,
   input logic [REV_W-1:0]   pend_rev
);
   a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid && rsp_rev == $past(req_rev));

   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid && !rsp_grant);

   a_r2_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == CMD_READ && rp_vec[req_rev]) |=> !rsp_grant);

   a_r3_prog_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == CMD_PROG && wp_vec[req_rev]) |=> !rsp_grant);

   a_r4_locked_erase: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == CMD_ERASE && wp_vec[req_rev]
       && !(pend_v && pend_rev == req_rev)) |=> !rsp_grant && $stable(wp_vec) && $stable(rp_vec));

   a_r5_unlock_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd != CMD_UNLOCK) |=> !pend_v);

   a_r6_rp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && (req_cmd == CMD_ERASE || req_cmd == CMD_ERASE_ALL))
      |=> (($past(rp_vec) & ~rp_vec) == '0));

   a_r8_erase_all_wp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == CMD_ERASE_ALL && wp_vec != '0) |=> !rsp_grant);

   a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == CMD_RSVD) |=> !rsp_grant && $stable(rp_vec) && $stable(wp_vec));

   generate
      if (DEVICE_WIDE) begin : g_dw
         a_r7_uniform: assert property (@(posedge clk) disable iff (!rst_n)
            rp_vec == '0 || rp_vec == '1);
      end
   endgenerate
endmodule

bind rev_guard rev_guard_chk #(.NUM_REV(NUM_REV), .DEVICE_WIDE(DEVICE_WIDE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_cmd   (req_cmd),
   .req_rev   (req_rev),
   .rsp_valid (rsp_valid),
   .rsp_grant (rsp_grant),
   .rsp_rev   (rsp_rev),
   .rp_vec    (rp_vec),
   .wp_vec    (wp_vec),
   .pend_v    (pend_v),
   .pend_rev  (pend_rev)
);

// File: tb/rev_guard_bench.sv
module rev_guard_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 38;

   // {req[3:0], cmd[2:0], rev[1:0], expected grant}
   localparam logic [9:0] VEC [NV] = '{
      {4'd1, 3'd0, 2'd0, 1'b1},  // R1 read after reset
      {4'd1, 3'd1, 2'd1, 1'b1},  // R1 program after reset
      {4'd1, 3'd2, 2'd2, 1'b1},  // R1 erase after reset
      {4'd2, 3'd3, 2'd1, 1'b1},  // R2 set read protect rev1
      {4'd2, 3'd0, 2'd1, 1'b0},  // R2 read rev1 denied
      {4'd2, 3'd0, 2'd0, 1'b1},  // R2 other rev readable
      {4'd2, 3'd1, 2'd1, 1'b1},  // R2 program still allowed
      {4'd2, 3'd3, 2'd2, 1'b1},  // R2 read protect rev2
      {4'd3, 3'd4, 2'd2, 1'b1},  // R3 set write protect rev2
      {4'd3, 3'd1, 2'd2, 1'b0},  // R3 program denied
      {4'd3, 3'd2, 2'd2, 1'b0},  // R3 erase denied
      {4'd5, 3'd5, 2'd2, 1'b1},  // R5 unlock rev2
      {4'd5, 3'd0, 2'd3, 1'b1},  // R5 read cancels unlock
      {4'd5, 3'd2, 2'd2, 1'b0},  // R5 erase denied after cancel
      {4'd5, 3'd5, 2'd3, 1'b1},  // R5 unlock rev3
      {4'd5, 3'd2, 2'd2, 1'b0},  // R5 mismatched rev denied
      {4'd4, 3'd5, 2'd2, 1'b1},  // R4 unlock rev2
      {4'd4, 3'd2, 2'd2, 1'b1},  // R4 erase granted
      {4'd4, 3'd1, 2'd2, 1'b1},  // R4 write protect gone
      {4'd4, 3'd0, 2'd2, 1'b1},  // R4 read protect gone
      {4'd4, 3'd2, 2'd2, 1'b1},  // R4 pending consumed, plain erase ok
      {4'd6, 3'd2, 2'd0, 1'b1},  // R6 erase rev0
      {4'd6, 3'd0, 2'd1, 1'b0},  // R6 rev1 still protected
      {4'd6, 3'd2, 2'd1, 1'b1},  // R6 erase rev1
      {4'd6, 3'd0, 2'd1, 1'b1},  // R6 rev1 readable
      {4'd8, 3'd4, 2'd3, 1'b1},  // R8 write protect rev3
      {4'd8, 3'd3, 2'd0, 1'b1},  // R8 read protect rev0
      {4'd8, 3'd6, 2'd0, 1'b0},  // R8 erase-all denied
      {4'd8, 3'd0, 2'd0, 1'b0},  // R8 rev0 still protected
      {4'd8, 3'd5, 2'd3, 1'b1},  // R8 unlock rev3
      {4'd8, 3'd2, 2'd3, 1'b1},  // R8 erase rev3
      {4'd8, 3'd6, 2'd1, 1'b1},  // R8 erase-all granted
      {4'd8, 3'd0, 2'd0, 1'b1},  // R8 rev0 readable
      {4'd10, 3'd4, 2'd1, 1'b1}, // R10 write protect rev1
      {4'd10, 3'd7, 2'd1, 1'b0}, // R10 reserved denied
      {4'd10, 3'd1, 2'd1, 1'b0}, // R10 flag unchanged
      {4'd10, 3'd5, 2'd1, 1'b1}, // R10 unlock
      {4'd10, 3'd2, 2'd1, 1'b1}  // R10 erase clears
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       a_valid = 1'b0, b_valid = 1'b0;
   logic [2:0] a_cmd = '0, b_cmd = '0;
   logic [1:0] a_rev = '0, b_rev = '0;
   logic       a_rv, a_gr, b_rv, b_gr;
   logic [1:0] a_rr, b_rr;
   int         n_chk = 0;
   int         n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rev_guard #(.NUM_REV(4), .DEVICE_WIDE(1'b0)) u_rev_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(a_valid), .req_cmd(a_cmd), .req_rev(a_rev),
      .rsp_valid(a_rv), .rsp_grant(a_gr), .rsp_rev(a_rr));

   rev_guard #(.NUM_REV(4), .DEVICE_WIDE(1'b1)) u_rev_guard_dw (
      .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_cmd(b_cmd), .req_rev(b_rev),
      .rsp_valid(b_rv), .rsp_grant(b_gr), .rsp_rev(b_rr));

   task automatic check(input int rq, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d actual=%h expected=%h at %0t", rq, act, exp, $time);
      end
   endtask

   // Drive on a falling edge, sample the response on the next falling edge.
   task automatic req(input bit dw, input logic [2:0] c, input logic [1:0] r,
                      input bit exp, input int rq);
      if (dw) begin b_valid = 1'b1; b_cmd = c; b_rev = r; end
      else    begin a_valid = 1'b1; a_cmd = c; a_rev = r; end
      @(negedge clk);
      if (dw) begin
         check(rq, {3'b0, b_gr}, {3'b0, exp});
         check(9, {1'b0, b_rv, b_rr}, {1'b0, 1'b1, r});   // R9 pulse and echo
      end else begin
         check(rq, {3'b0, a_gr}, {3'b0, exp});
         check(9, {1'b0, a_rv, a_rr}, {1'b0, 1'b1, r});   // R9 pulse and echo
      end
   endtask

   task automatic idle();
      a_valid = 1'b0; b_valid = 1'b0;
      @(negedge clk);
      check(9, {2'b0, a_rv, b_rv}, 4'b0);                 // R9 no pulse when idle
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(1, {2'b0, a_rv, b_rv}, 4'b0);                 // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check(1, {2'b0, a_rv, b_rv}, 4'b0);                 // R1 quiet after reset

      for (int i = 0; i < NV; i++)
         req(1'b0, VEC[i][5:3], VEC[i][2:1], VEC[i][0], int'(VEC[i][9:6]));
      idle();

      // R7 device-wide read protection
      req(1'b1, 3'd0, 2'd3, 1'b1, 7);
      req(1'b1, 3'd3, 2'd1, 1'b1, 7);
      req(1'b1, 3'd0, 2'd0, 1'b0, 7);
      req(1'b1, 3'd0, 2'd3, 1'b0, 7);
      req(1'b1, 3'd1, 2'd0, 1'b1, 7);
      req(1'b1, 3'd2, 2'd1, 1'b1, 7);
      req(1'b1, 3'd0, 2'd1, 1'b0, 7);
      req(1'b1, 3'd6, 2'd0, 1'b1, 7);
      req(1'b1, 3'd0, 2'd2, 1'b1, 7);
      idle();

      // R1 reset mid-run clears flags
      req(1'b0, 3'd4, 2'd0, 1'b1, 1);
      req(1'b0, 3'd3, 2'd0, 1'b1, 1);
      a_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check(1, {3'b0, a_rv}, 4'b0);                        // R1 response cleared
      rst_n = 1'b1;
      @(negedge clk);
      req(1'b0, 3'd1, 2'd0, 1'b1, 1);
      req(1'b0, 3'd0, 2'd0, 1'b1, 1);
      req(1'b0, 3'd2, 2'd0, 1'b1, 1);
      idle();
      summary();
   end
endmodule